// File: doc/BRIEF.md
# Byte-Wide Erasable ROM Bus Mode Decoder

This block is a synthesizable behavioural model of the control and data-path logic of a byte-wide, electrically erasable read-only memory. Six control inputs pick the operating mode: three active-low strobes (select, output enable, program pulse), the lowest address bit, and two digital flags. One flag stands for high voltage on the address line used for identification and erase. The other stands for high voltage on the programming supply. The block keeps a storage array whose depth is set by a parameter. It can return two fixed identifier bytes and drives a byte-wide bus, given as a data value plus a drive-enable, so that the high-impedance cases can be observed.

Writes can only clear bits. A program pulse stores the AND of the old byte and the bus byte. The only way to set bits back to 1 is a whole-array erase, which writes FF hex into every byte. Program and erase happen at the end of the program pulse (the rising edge of `pgm_n`), sampled in the `clk` domain. The mode in force during the last sampled low cycle of the pulse decides what the pulse does. Reads and identifier readout are combinational from the pins and the stored contents.

Top module: `nvbyte_store`

## Requirements
- R1: While `sel_n` is 1, `dout_en` is 0 whatever `oe_n`, `pgm_n`, `hv_a9` and `hv_supply` are.
- R2: While `sel_n` is 0 and `oe_n` is 1, `dout_en` is 0.
- R3: With `sel_n`=0, `oe_n`=0, `hv_supply`=0 and `hv_a9`=0, `dout_en` is 1 and `dout` is the stored byte at `addr`.
- R4: A program pulse stores `old & din` at the sampled `addr`, so bits only go from 1 to 0. The pulse counts as a program when `pgm_n` rises and the last sample before the rise had `sel_n`=0, `oe_n`=1, `hv_supply`=1 and `hv_a9`=0.
- R5: A pulse whose last low sample had `sel_n`=0, `oe_n`=1, `hv_supply`=1, `hv_a9`=1 and `addr[0]`=0 sets every byte to FF hex. The other address bits do not matter.
- R6: With `sel_n`=0, `oe_n`=0 and `hv_supply`=1, the bus carries the stored byte at `addr` when `pgm_n`=1 and is not driven when `pgm_n`=0. This holds whatever `hv_a9` is.
- R7: With `sel_n`=0, `oe_n`=0, `hv_supply`=0 and `hv_a9`=1, `dout` is DA hex when `addr[0]`=0 and 01 hex when `addr[0]`=1, with `dout_en`=1.
- R8: A pulse with any other combination leaves the whole array unchanged. This covers no supply flag, `sel_n`=1, `oe_n`=0, and `hv_a9`=1 with `addr[0]`=1. Only one of program or erase can happen per pulse.
- R9: After reset every byte reads FF hex and the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the program strobe |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| pgm_n | input | 1 | Active-low program/erase pulse |
| addr | input | AW | Byte address; bit 0 also selects the identifier |
| hv_a9 | input | 1 | High voltage present on the identification/erase line |
| hv_supply | input | 1 | High voltage present on the programming supply |
| din | input | 8 | Byte offered for programming |
| dout | output | 8 | Byte driven onto the bus |
| dout_en | output | 1 | 1 when the bus is driven, 0 for high impedance |

## Verification
The hardest cases to reach are the pulses that must do nothing. From the ports, a correct no-op and a skipped update of a byte that happens to hold the same value look alike. So before the ignored pulses are sent, the bench fills every byte with a distinct pattern, ANDed over two passes. Each ignored pulse then carries a data byte that would visibly change the array, and the whole array is read back after every one. The control sweeps are also ordered so that the program line never rises while program conditions hold, which would give a real write by accident.

// File: rtl/nvbyte_pkg.sv
`timescale 1ns/1ps
package nvbyte_pkg;

  typedef logic [7:0] byte_t;

  localparam byte_t ERASED_BYTE = 8'hFF;

  typedef enum logic [2:0] {
    M_STANDBY,
    M_OUT_OFF,
    M_READ,
    M_IDENT,
    M_VERIFY,
    M_PROGRAM,
    M_ERASE
  } op_mode_e;

  // Mode selection from the control pins; the supply flag takes precedence
  // over the identification flag when the outputs are enabled.
  function automatic op_mode_e decode_mode(input logic sel_n, input logic oe_n,
                                           input logic pgm_n, input logic a0,
                                           input logic hv_a9, input logic hv_sup);
    if (sel_n) return M_STANDBY;
    if (!oe_n) begin
      if (hv_sup) return pgm_n ? M_VERIFY : M_OUT_OFF;
      if (hv_a9)  return M_IDENT;
      return M_READ;
    end
    if (hv_sup && !pgm_n) begin
      if (!hv_a9) return M_PROGRAM;
      if (!a0)    return M_ERASE;
    end
    return M_OUT_OFF;
  endfunction

  // Programming can only clear bits.
  function automatic byte_t clear_bits(input byte_t old_b, input byte_t wr_b);
    return old_b & wr_b;
  endfunction

  function automatic byte_t ident_code(input logic a0, input byte_t mfr, input byte_t dev);
    return a0 ? dev : mfr;
  endfunction

  function automatic logic mode_drives(input op_mode_e m);
    return (m == M_READ) || (m == M_VERIFY) || (m == M_IDENT);
  endfunction

endpackage

// File: rtl/nvbyte_mode_dec.sv
`timescale 1ns/1ps
module nvbyte_mode_dec
  import nvbyte_pkg::*;
(
  input  logic     sel_n,
  input  logic     oe_n,
  input  logic     pgm_n,
  input  logic     a0,
  input  logic     hv_a9,
  input  logic     hv_supply,
  output op_mode_e mode,
  output logic     drive
);

  always_comb begin
    mode  = decode_mode(sel_n, oe_n, pgm_n, a0, hv_a9, hv_supply);
    drive = mode_drives(mode);
  end

endmodule

// File: rtl/nvbyte_strobe_trk.sv
`timescale 1ns/1ps
module nvbyte_strobe_trk
  import nvbyte_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pgm_n,
  input  op_mode_e      live_mode,
  input  logic [AW-1:0] addr,
  input  byte_t         din,
  output logic          prog_fire,
  output logic          erase_fire,
  output logic [AW-1:0] cmd_addr,
  output byte_t         cmd_din
);

  localparam int STAGES = 2;

  logic          pgm_q  [STAGES];
  op_mode_e      mode_q [STAGES];
  logic [AW-1:0] addr_q [STAGES];
  byte_t         din_q  [STAGES];
  logic          pulse_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        pgm_q[s]  <= 1'b1;
        mode_q[s] <= M_STANDBY;
        addr_q[s] <= '0;
        din_q[s]  <= '0;
      end
    end else begin
      pgm_q[0]  <= pgm_n;
      mode_q[0] <= live_mode;
      addr_q[0] <= addr;
      din_q[0]  <= din;
      for (int s = 1; s < STAGES; s++) begin
        pgm_q[s]  <= pgm_q[s-1];
        mode_q[s] <= mode_q[s-1];
        addr_q[s] <= addr_q[s-1];
        din_q[s]  <= din_q[s-1];
      end
    end
  end

  // End of pulse: newest sample high, older sample low. The older sample
  // carries the mode held during the last low cycle.
  assign pulse_end  = pgm_q[0] & ~pgm_q[STAGES-1];
  assign prog_fire  = pulse_end && (mode_q[STAGES-1] == M_PROGRAM);
  assign erase_fire = pulse_end && (mode_q[STAGES-1] == M_ERASE);
  assign cmd_addr   = addr_q[STAGES-1];
  assign cmd_din    = din_q[STAGES-1];

endmodule

// File: rtl/nvbyte_array.sv
`timescale 1ns/1ps
module nvbyte_array
  import nvbyte_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_fire,
  input  logic          erase_fire,
  input  logic [AW-1:0] cmd_addr,
  input  byte_t         cmd_din,
  input  logic [AW-1:0] rd_addr,
  output byte_t         rd_word,
  output byte_t         cmd_word
);

  localparam int DEPTH = 1 << AW;

  byte_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
    end else if (erase_fire) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
    end else if (prog_fire) begin
      mem[cmd_addr] <= clear_bits(mem[cmd_addr], cmd_din);
    end
  end

  assign rd_word  = mem[rd_addr];
  assign cmd_word = mem[cmd_addr];

endmodule

// File: rtl/nvbyte_store.sv
`timescale 1ns/1ps
module nvbyte_store
  import nvbyte_pkg::*;
#(
  parameter int    AW       = 6,
  parameter byte_t MFR_CODE = 8'hDA,
  parameter byte_t DEV_CODE = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          oe_n,
  input  logic          pgm_n,
  input  logic [AW-1:0] addr,
  input  logic          hv_a9,
  input  logic          hv_supply,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_en
);

  op_mode_e      live_mode;
  logic          live_drive;
  logic          prog_fire;
  logic          erase_fire;
  logic [AW-1:0] cmd_addr;
  byte_t         cmd_din;
  byte_t         cmd_word;
  byte_t         rd_word;

  nvbyte_mode_dec u_dec (
    .sel_n     (sel_n),
    .oe_n      (oe_n),
    .pgm_n     (pgm_n),
    .a0        (addr[0]),
    .hv_a9     (hv_a9),
    .hv_supply (hv_supply),
    .mode      (live_mode),
    .drive     (live_drive)
  );

  nvbyte_strobe_trk #(.AW(AW)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pgm_n      (pgm_n),
    .live_mode  (live_mode),
    .addr       (addr),
    .din        (din),
    .prog_fire  (prog_fire),
    .erase_fire (erase_fire),
    .cmd_addr   (cmd_addr),
    .cmd_din    (cmd_din)
  );

  nvbyte_array #(.AW(AW)) u_arr (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_fire  (prog_fire),
    .erase_fire (erase_fire),
    .cmd_addr   (cmd_addr),
    .cmd_din    (cmd_din),
    .rd_addr    (addr),
    .rd_word    (rd_word),
    .cmd_word   (cmd_word)
  );

  always_comb begin
    dout_en = live_drive;
    unique case (live_mode)
      M_READ, M_VERIFY: dout = rd_word;
      M_IDENT:          dout = ident_code(addr[0], MFR_CODE, DEV_CODE);
      default:          dout = '0;
    endcase
  end

endmodule

// File: rtl/nvbyte_store_chk.sv
`timescale 1ns/1ps
module nvbyte_store_chk
  import nvbyte_pkg::*;
#(
  parameter int    AW       = 6,
  parameter byte_t MFR_CODE = 8'hDA,
  parameter byte_t DEV_CODE = 8'h01
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_n,
  input logic          oe_n,
  input logic          pgm_n,
  input logic          a0,
  input logic          hv_a9,
  input logic          hv_sup,
  input logic [7:0]    dout,
  input logic          dout_en,
  input logic          prog_fire,
  input logic          erase_fire,
  input logic [AW-1:0] cmd_addr,
  input byte_t         cmd_din,
  input byte_t         cmd_word
);

  p_standby_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> !dout_en);

  p_disable_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && oe_n) |-> !dout_en);

  p_read_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !oe_n && !hv_sup && !hv_a9) |-> dout_en);

  p_program_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(prog_fire) && (cmd_addr == $past(cmd_addr)))
      |-> (cmd_word == ($past(cmd_word) & $past(cmd_din))));

  p_erase_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_fire |=> (cmd_word == 8'hFF));

  p_verify_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !oe_n && hv_sup) |-> (dout_en == pgm_n));

  p_ident_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !oe_n && hv_a9 && !hv_sup)
      |-> (dout_en && (dout == (a0 ? DEV_CODE : MFR_CODE))));

  p_single_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_fire, erase_fire}));

endmodule

bind nvbyte_store nvbyte_store_chk #(
  .AW(AW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_n      (sel_n),
  .oe_n       (oe_n),
  .pgm_n      (pgm_n),
  .a0         (addr[0]),
  .hv_a9      (hv_a9),
  .hv_sup     (hv_supply),
  .dout       (dout),
  .dout_en    (dout_en),
  .prog_fire  (prog_fire),
  .erase_fire (erase_fire),
  .cmd_addr   (cmd_addr),
  .cmd_din    (cmd_din),
  .cmd_word   (cmd_word)
);

// File: tb/nvbyte_store_bench.sv
`timescale 1ns/1ps
module nvbyte_store_bench;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          pgm_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          hv_a9 = 1'b0;
  logic          hv_supply = 1'b0;
  logic [7:0]    din = 8'h00;
  logic [7:0]    dout;
  logic          dout_en;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [DEPTH];

  always #4 clk = ~clk;

  nvbyte_store #(.AW(AW)) u_nvbyte_store (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .addr(addr), .hv_a9(hv_a9), .hv_supply(hv_supply), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [7:0] pat(input int a, input int k);
    return 8'(((a * 29) + (k * 71)) ^ (8'h5A + k));
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual en/data=%b/%h expected en/data=%b/%h",
               req, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  task automatic idle();
    sel_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1; hv_a9 = 1'b0; hv_supply = 1'b0;
  endtask

  // Bus observation with the given mode pins; sampled 1 ns after the negedge.
  task automatic look(input logic s, input logic o, input logic p, input logic a9,
                      input logic sup, input logic [AW-1:0] ad);
    @(negedge clk);
    sel_n = s; oe_n = o; pgm_n = p; hv_a9 = a9; hv_supply = sup; addr = ad;
    #1;
  endtask

  task automatic check_all(input string req, input logic verify_mode);
    for (int a = 0; a < DEPTH; a++) begin
      look(1'b0, 1'b0, 1'b1, 1'b0, verify_mode, AW'(a));
      chk(req, {dout_en, dout}, {1'b1, model[a]});
    end
    @(negedge clk); idle();
  endtask

  task automatic pulse(input logic s, input logic o, input logic a9, input logic sup,
                       input logic [AW-1:0] ad, input logic [7:0] d);
    @(negedge clk);
    sel_n = s; oe_n = o; pgm_n = 1'b1; hv_a9 = a9; hv_supply = sup; addr = ad; din = d;
    @(negedge clk); pgm_n = 1'b0;
    repeat (3) @(negedge clk);
    pgm_n = 1'b1;
    repeat (4) @(negedge clk);
    idle();
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R9: idle bus and blank array after reset
    chk("R9 idle", {dout_en, 8'h00}, 9'h000);
    check_all("R9 blank", 1'b0);

    // R1: select high, every other control combination
    for (int c = 0; c < 16; c++) begin
      look(1'b1, c[0], c[1], c[2], c[3], AW'(c * 5));
      chk("R1", {dout_en, 8'h00}, 9'h000);
    end
    // R2: outputs disabled; pgm_n never rises under program conditions
    for (int c = 0; c < 8; c++) begin
      if (c[2] && !c[0]) continue;
      look(1'b0, 1'b1, c[0], c[1], c[2], AW'(c * 7 + 1));
      chk("R2", {dout_en, 8'h00}, 9'h000);
    end
    @(negedge clk); idle();
    check_all("R8 after sweeps", 1'b0);

    // R4: two program passes, AND accumulation
    for (int k = 1; k <= 2; k++) begin
      for (int a = 0; a < DEPTH; a++) begin
        pulse(1'b0, 1'b1, 1'b0, 1'b1, AW'(a), pat(a, k));
        model[a] = model[a] & pat(a, k);
      end
      check_all("R4/R3 read", 1'b0);
    end
    // R6: verify mode reads the same contents
    check_all("R6 verify", 1'b1);
    look(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, AW'(3));
    chk("R6 pgm low off", {dout_en, 8'h00}, 9'h000);
    look(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, AW'(4));
    chk("R6 verify over ident", {dout_en, dout}, {1'b1, model[4]});
    @(negedge clk); idle();

    // R7: identifier bytes over several addresses
    for (int a = 0; a < 8; a++) begin
      look(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, AW'(a * 9));
      chk("R7", {dout_en, dout}, {1'b1, ((a * 9) % 2 == 1) ? 8'h01 : 8'hDA});
    end
    @(negedge clk); idle();

    // R8: pulses that must not change anything
    pulse(1'b0, 1'b1, 1'b0, 1'b0, AW'(10), 8'h00);   // no supply flag
    check_all("R8 no supply", 1'b0);
    pulse(1'b1, 1'b1, 1'b0, 1'b1, AW'(11), 8'h00);   // not selected
    check_all("R8 deselected", 1'b0);
    pulse(1'b0, 1'b0, 1'b0, 1'b1, AW'(12), 8'h00);   // outputs enabled
    check_all("R8 oe low", 1'b0);
    pulse(1'b0, 1'b1, 1'b1, 1'b1, AW'(13), 8'h00);   // erase with a0 high
    check_all("R8 erase a0 high", 1'b0);

    // R5: erase with a0 low but other address bits set
    pulse(1'b0, 1'b1, 1'b1, 1'b1, AW'(42), 8'h00);
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    check_all("R5 erase", 1'b0);

    // R4/R5: reprogram a few bytes, then erase again
    for (int a = 0; a < DEPTH; a += 7) begin
      pulse(1'b0, 1'b1, 1'b0, 1'b1, AW'(a), pat(a, 3));
      model[a] = model[a] & pat(a, 3);
    end
    check_all("R4 reprogram", 1'b0);
    pulse(1'b0, 1'b1, 1'b1, 1'b1, AW'(0), 8'hFF);
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    check_all("R5 erase again", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule